// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a shift register of the resolved outcomes of the most recent branches, called the global history. The history is combined with low bits of the branch address to pick one saturating counter in a pattern history table. The top bit of that counter is the prediction. Set `HIST_BITS` to m and `CTR_BITS` to n to build an (m,n) predictor. With m = 0 the block is a plain per-address table of counters.

A fetch stage drives a PC on the lookup port and reads back a taken/not-taken bit in the same cycle. When a branch resolves, the execute stage drives the update port with the branch PC and its actual outcome. That counter is trained, and the outcome is shifted into the history at the next clock edge. A mode input set at configuration time picks how the table index is formed. In the concatenating mode, the history sits above the address bits. In the hashing mode, the history is XORed into the low end of a wider address field.

Top module: `gcp_predictor`

## Requirements
- R1: After reset the history is all zeros and every counter holds the weakly-not-taken value 01 (for n=2), so every lookup returns not taken.
- R2: A lookup returns taken exactly when the selected counter has its most significant bit set: states 10 and 11 predict taken, 00 and 01 predict not taken.
- R3: An update with outcome taken increments the selected counter, and one with outcome not taken decrements it. The counter saturates at 11 and at 00.
- R4: Starting from a strong state (00 or 11), the prediction for an entry changes only after two consecutive opposite outcomes at that entry.
- R5: Each valid update shifts the history left by one and places the resolved outcome in bit 0, dropping the oldest bit. Without a valid update the history holds.
- R6: With `idx_mode` = 0 the table index is {history, pc[ADDR_BITS+PC_LSB-1:PC_LSB]}.
- R7: With `idx_mode` = 1 the table index is pc[HIST_BITS+ADDR_BITS+PC_LSB-1:PC_LSB] XOR the history, zero-extended.
- R8: An update changes only the counter selected by the update PC and the history present before that update. All other counters keep their values.
- R9: The lookup output depends combinationally on `lk_pc` and the current state. An update becomes visible to lookups from the cycle after the clock edge that takes it.
- R10: With HIST_BITS = 0 the index is pc[ADDR_BITS+PC_LSB-1:PC_LSB] in both modes. Each address then has a single counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_mode | input | 1 | Index formation: 0 concatenate, 1 XOR hash; static while out of reset |
| lk_pc | input | PC_WIDTH | Address of the branch being looked up |
| lk_taken | output | 1 | Predicted direction for `lk_pc` |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_WIDTH | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The assertions assume that `idx_mode` stays fixed for as long as reset is released. The bench keeps to this with three instances, each with a hard-wired mode or history length, and drives none of them with a mode change. The hold check on `lk_taken` assumes that a cycle with no update leaves every counter untouched. The bench keeps to this as well: update inputs change only at falling edges, and no update pulse is ever shorter than a full cycle.

// File: rtl/gcp_pkg.sv
package gcp_pkg;

  typedef enum logic {
    IDX_CONCAT = 1'b0,
    IDX_XOR    = 1'b1
  } idx_mode_e;

endpackage

// File: rtl/gcp_history.sv
module gcp_history #(
  parameter int HIST_BITS = 2,
  localparam int HW = (HIST_BITS == 0) ? 1 : HIST_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_valid,
  input  logic          upd_taken,
  output logic [HW-1:0] hist
);

  generate
    if (HIST_BITS == 0) begin : g_none
      logic unused_hist_in;
      assign unused_hist_in = clk ^ rst_n ^ upd_valid ^ upd_taken;
      assign hist = '0;
    end else begin : g_reg
      logic [HW-1:0] hist_q;
      logic [HW-1:0] hist_d;

      always_comb begin
        hist_d = hist_q;
        if (upd_valid) begin
          if (HW == 1) hist_d = upd_taken;
          else         hist_d = {hist_q[HW-2:0], upd_taken};
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
      end

      assign hist = hist_q;

      a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(hist_q));

      a_r5_newest: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> hist_q[0] == $past(upd_taken));

      if (HW >= 2) begin : g_shift_chk
        a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n)
          upd_valid |=> hist_q[HW-1:1] == $past(hist_q[HW-2:0]));
      end
    end
  endgenerate

endmodule

// File: rtl/gcp_index.sv
module gcp_index #(
  parameter int HIST_BITS = 2,
  parameter int ADDR_BITS = 10,
  parameter int PC_WIDTH  = 32,
  parameter int PC_LSB    = 2,
  localparam int HW    = (HIST_BITS == 0) ? 1 : HIST_BITS,
  localparam int IDX_W = HIST_BITS + ADDR_BITS
) (
  input  logic [PC_WIDTH-1:0]  pc,
  input  logic [HW-1:0]        hist,
  input  gcp_pkg::idx_mode_e   mode,
  output logic [IDX_W-1:0]     idx
);

  logic [IDX_W-1:0] pc_field;
  logic [IDX_W-1:0] cat_idx;
  logic [IDX_W-1:0] hash_idx;
  logic             unused_pc;

  assign pc_field  = pc[PC_LSB +: IDX_W];
  assign unused_pc = ^pc;

  generate
    if (HIST_BITS == 0) begin : g_flat
      assign cat_idx = pc_field;
    end else begin : g_cat
      assign cat_idx = {hist, pc_field[ADDR_BITS-1:0]};
    end
  endgenerate

  assign hash_idx = pc_field ^ IDX_W'(hist);

  always_comb begin
    case (mode)
      gcp_pkg::IDX_XOR: idx = hash_idx;
      default:          idx = cat_idx;
    endcase
  end

endmodule

// File: rtl/gcp_sat_next.sv
module gcp_sat_next #(
  parameter int CTR_BITS = 2
) (
  input  logic [CTR_BITS-1:0] cur,
  input  logic                taken,
  output logic [CTR_BITS-1:0] nxt
);

  localparam logic [CTR_BITS-1:0] CMAX = '1;
  localparam logic [CTR_BITS-1:0] CMIN = '0;

  always_comb begin
    if (taken) nxt = (cur == CMAX) ? cur : cur + CTR_BITS'(1);
    else       nxt = (cur == CMIN) ? cur : cur - CTR_BITS'(1);
  end

endmodule

// File: rtl/gcp_pht.sv
module gcp_pht #(
  parameter int IDX_W    = 12,
  parameter int CTR_BITS = 2,
  localparam int DEPTH   = 1 << IDX_W,
  localparam int RST_INT = (1 << (CTR_BITS - 1)) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_taken,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken
);

  localparam logic [CTR_BITS-1:0] RST_VAL = CTR_BITS'(RST_INT);
  localparam logic [CTR_BITS-1:0] CMAX    = '1;

  logic [CTR_BITS-1:0] ctr_q [DEPTH];
  logic [CTR_BITS-1:0] upd_cur;
  logic [CTR_BITS-1:0] upd_nxt;

  assign upd_cur = ctr_q[upd_idx];

  gcp_sat_next #(.CTR_BITS(CTR_BITS)) u_sat (
    .cur   (upd_cur),
    .taken (upd_taken),
    .nxt   (upd_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= RST_VAL;
    end else if (upd_en) begin
      ctr_q[upd_idx] <= upd_nxt;
    end
  end

  assign lk_taken = ctr_q[lk_idx][CTR_BITS-1];

  a_r3_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_taken && upd_cur == CMAX) |=> ctr_q[$past(upd_idx)] == CMAX);

  a_r3_sat_bot: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_taken && upd_cur == '0) |=> ctr_q[$past(upd_idx)] == '0);

  a_r3_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_taken && upd_cur != '0)
      |=> ctr_q[$past(upd_idx)] == $past(upd_cur) - CTR_BITS'(1));

  a_r3_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_taken && upd_cur != CMAX)
      |=> ctr_q[$past(upd_idx)] == $past(upd_cur) + CTR_BITS'(1));

endmodule

// File: rtl/gcp_predictor.sv
module gcp_predictor #(
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2,
  parameter int ADDR_BITS = 10,
  parameter int PC_WIDTH  = 32,
  parameter int PC_LSB    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idx_mode,
  input  logic [PC_WIDTH-1:0] lk_pc,
  output logic                lk_taken,
  input  logic                upd_valid,
  input  logic [PC_WIDTH-1:0] upd_pc,
  input  logic                upd_taken
);

  localparam int HW    = (HIST_BITS == 0) ? 1 : HIST_BITS;
  localparam int IDX_W = HIST_BITS + ADDR_BITS;

  gcp_pkg::idx_mode_e mode;
  logic [HW-1:0]      hist;
  logic [IDX_W-1:0]   lk_idx;
  logic [IDX_W-1:0]   upd_idx;

  assign mode = gcp_pkg::idx_mode_e'(idx_mode);

  gcp_history #(.HIST_BITS(HIST_BITS)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .hist      (hist)
  );

  gcp_index #(
    .HIST_BITS (HIST_BITS),
    .ADDR_BITS (ADDR_BITS),
    .PC_WIDTH  (PC_WIDTH),
    .PC_LSB    (PC_LSB)
  ) u_lk_index (
    .pc   (lk_pc),
    .hist (hist),
    .mode (mode),
    .idx  (lk_idx)
  );

  gcp_index #(
    .HIST_BITS (HIST_BITS),
    .ADDR_BITS (ADDR_BITS),
    .PC_WIDTH  (PC_WIDTH),
    .PC_LSB    (PC_LSB)
  ) u_upd_index (
    .pc   (upd_pc),
    .hist (hist),
    .mode (mode),
    .idx  (upd_idx)
  );

  gcp_pht #(.IDX_W(IDX_W), .CTR_BITS(CTR_BITS)) u_pht (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_idx    (lk_idx),
    .lk_taken  (lk_taken),
    .upd_en    (upd_valid),
    .upd_idx   (upd_idx),
    .upd_taken (upd_taken)
  );

  a_r6_mode_static: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(idx_mode));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(upd_valid) && $stable(lk_pc)) |-> $stable(lk_taken));

endmodule

// File: tb/gcp_predictor_tb.sv
`timescale 1ns/1ps
module gcp_predictor_tb;

  localparam int PW = 16;
  localparam int AB = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] lk_pc = '0;
  logic          upd_valid = 1'b0;
  logic [PW-1:0] upd_pc = '0;
  logic          upd_taken = 1'b0;
  logic          p_cat, p_xor, p_flat;

  int total = 0;
  int bad = 0;
  int c_cat [32];
  int c_xor [32];
  int c_flat [8];
  int h_cat = 0;
  int h_xor = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  gcp_predictor #(.HIST_BITS(2), .CTR_BITS(2), .ADDR_BITS(AB), .PC_WIDTH(PW), .PC_LSB(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .idx_mode(1'b0), .lk_pc(lk_pc), .lk_taken(p_cat),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  gcp_predictor #(.HIST_BITS(2), .CTR_BITS(2), .ADDR_BITS(AB), .PC_WIDTH(PW), .PC_LSB(2)) u_dut_xor (
    .clk(clk), .rst_n(rst_n), .idx_mode(1'b1), .lk_pc(lk_pc), .lk_taken(p_xor),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  gcp_predictor #(.HIST_BITS(0), .CTR_BITS(2), .ADDR_BITS(AB), .PC_WIDTH(PW), .PC_LSB(2)) u_dut_flat (
    .clk(clk), .rst_n(rst_n), .idx_mode(1'b0), .lk_pc(lk_pc), .lk_taken(p_flat),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  function automatic int midx(int m, bit x, int pc, int h);
    int p;
    p = pc >> 2;
    if (m == 0) return p & 7;
    if (!x) return (h << AB) | (p & 7);
    return (p & 31) ^ h;
  endfunction

  function automatic int sat(int c, bit t);
    if (t) return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction

  task automatic chk(string req, string inst, bit act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s pc=%0h actual=%0b expected=%0b", req, inst, lk_pc, act, exp);
    end
  endtask

  // R9: output sampled before the edge reflects state after the previous edge
  task automatic step(string req, bit uv, int upc, bit ut, int lpc);
    int i0, i1, i2;
    @(negedge clk);
    upd_valid = uv;
    upd_pc = PW'(upc);
    upd_taken = ut;
    lk_pc = PW'(lpc);
    #1;
    chk(req, "cat", p_cat,  c_cat[midx(2, 1'b0, lpc, h_cat)] >= 2);
    chk(req, "xor", p_xor,  c_xor[midx(2, 1'b1, lpc, h_xor)] >= 2);
    chk(req, "flat", p_flat, c_flat[midx(0, 1'b0, lpc, 0)] >= 2);
    @(posedge clk);
    if (uv) begin
      i0 = midx(2, 1'b0, upc, h_cat);
      i1 = midx(2, 1'b1, upc, h_xor);
      i2 = midx(0, 1'b0, upc, 0);
      c_cat[i0] = sat(c_cat[i0], ut);
      c_xor[i1] = sat(c_xor[i1], ut);
      c_flat[i2] = sat(c_flat[i2], ut);
      h_cat = ((h_cat << 1) | int'(ut)) & 3;
      h_xor = ((h_xor << 1) | int'(ut)) & 3;
    end
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin c_cat[i] = 1; c_xor[i] = 1; end
    for (int i = 0; i < 8; i++) c_flat[i] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every entry reachable with zero history predicts not taken
    for (int i = 0; i < 32; i++) step("R1", 1'b0, 0, 1'b0, i * 4);

    // R3 R4 R2: train one address up to saturation, then two opposite outcomes
    step("R3", 1'b1, 'h14, 1'b1, 'h14);
    step("R2", 1'b1, 'h14, 1'b1, 'h14);
    step("R3", 1'b1, 'h14, 1'b1, 'h14);
    step("R4", 1'b1, 'h14, 1'b0, 'h14);
    step("R4", 1'b1, 'h14, 1'b0, 'h14);
    step("R4", 1'b1, 'h14, 1'b0, 'h14);
    step("R3", 1'b1, 'h14, 1'b0, 'h14);
    step("R3", 1'b1, 'h14, 1'b1, 'h14);
    step("R4", 1'b1, 'h14, 1'b1, 'h14);
    step("R4", 1'b0, 'h14, 1'b0, 'h14);

    // R5 R6 R7 R10: a repeating pattern so history separates the entries
    for (int k = 0; k < 40; k++)
      step("R5", 1'b1, 'h8, (k % 3) != 0, 'h8);

    // R8 R6 R7: pseudo-random traffic compared in every cycle
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(k[0] ? "R6" : "R7", lfsr[0] | lfsr[1], int'(lfsr[8:2]) << 2,
           lfsr[9] | lfsr[10], int'(lfsr[15:11]) << 2);
    end

    // R8 R10: full sweep with no updates, all entries for the current history
    for (int i = 0; i < 32; i++) step("R8", 1'b0, 0, 1'b0, i * 4);
    for (int i = 0; i < 32; i++) step("R10", 1'b0, 0, 1'b0, (i * 4) + 'h200);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule